// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block is the part of a small processor model that switches control flow when an exception is taken and switches it back when the handler finishes. It watches seven request lines (reset, undefined instruction, supervisor call, prefetch abort, data abort, normal interrupt and fast interrupt). In any cycle it picks one winner by fixed priority, moves into the privileged mode that belongs to that request, and stores two values in the registers private to that mode: the return address and the status word that was current. It then raises the interrupt-disable bits that the request calls for and issues a new program counter. That counter is a programmable, 32-byte-aligned table base plus a fixed offset for the request type.

A return request copies the current mode's saved status word back into the live status word and loads the program counter from that mode's link register. Each privileged mode has its own saved copies. A fast interrupt can therefore preempt a normal-interrupt handler, and the two returns unwind in order. Instruction decode, the general register file and stack saving are outside the block. The pipeline supplies `cur_pc`, and the block saves `cur_pc + 4` as the return address.

Top module: `exc_seq`

## Requirements
- R1: After hardware reset the status word is mode 10011 (supervisor), with interrupt-disable = 1, fast-disable = 1 and flags = 0. `pc_load` is 0. Every banked saved-status copy holds mode 10000 (user) with both disable bits 0 and flags 0, and every banked link register holds 0.
- R2: Mode encodings are user 10000, fast interrupt 10001, interrupt 10010, supervisor 10011, abort 10111 and undefined 11011. Reset and supervisor call enter supervisor mode. Prefetch abort and data abort enter abort mode. Undefined instruction enters undefined mode. Normal and fast interrupt enter their own modes.
- R3: When several requests are raised in the same cycle, the winner is chosen in this order: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, supervisor call.
- R4: The new program counter is the table base plus a fixed offset. The offsets are reset 0x00, undefined 0x04, supervisor call 0x08, prefetch abort 0x0C, data abort 0x10, interrupt 0x18 and fast interrupt 0x1C. The base written through `vbase_we` has its low 5 bits forced to 0.
- R5: Every entry sets the interrupt-disable bit. Fast-interrupt entry and reset entry also set the fast-disable bit. All other entries leave the fast-disable bit unchanged.
- R6: Every entry other than reset writes `cur_pc + 4` into the target mode's link register and the previous status word into that mode's saved-status register. No other mode's copies change.
- R7: A normal interrupt is not taken while the interrupt-disable bit is 1. A fast interrupt is not taken while the fast-disable bit is 1.
- R8: A return request in a privileged mode restores the whole status word from that mode's saved copy and drives `pc_target` from that mode's link register. `pc_load` is 1 for that one cycle. A return request in user mode has no effect.
- R9: A fast interrupt taken inside a normal-interrupt handler saves the handler's state in the fast-interrupt bank. The first return resumes the handler and the second return resumes user code.
- R10: `flags_we` updates the flags only in a cycle with no entry and no return. Any entry or return raises `pc_load` for exactly one cycle, and `pc_load` is 1 in no other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_reset | input | 1 | Reset exception request |
| req_undef | input | 1 | Undefined instruction request |
| req_svc | input | 1 | Supervisor call request |
| req_pabt | input | 1 | Prefetch abort request |
| req_dabt | input | 1 | Data abort request |
| irq | input | 1 | Normal interrupt request level |
| fiq | input | 1 | Fast interrupt request level |
| ret_req | input | 1 | Return from exception |
| cur_pc | input | AW | Address of the current instruction |
| vbase_we | input | 1 | Write strobe for the table base |
| vbase_in | input | AW | New table base |
| flags_we | input | 1 | Write strobe for the ALU flags |
| flags_in | input | 4 | New ALU flags |
| pc_load | output | 1 | One-cycle strobe: load `pc_target` |
| pc_target | output | AW | New program counter |
| mode | output | 5 | Current processor mode |
| irq_dis | output | 1 | Interrupt-disable bit |
| fiq_dis | output | 1 | Fast-disable bit |
| flags | output | 4 | Current ALU flags |

## Verification
A corrupted banked register stays hidden until the matching return. At that point it appears as a wrong `pc_target` or a wrong restored mode, flags or disable bits, one cycle after `ret_req`. For that reason each entry is paired with its return, and the nested fast-interrupt case checks that the outer handler's copies survive the inner entry. A wrong arbitration or offset shows at once as a wrong `mode` or `pc_target` in the cycle after the request. Simultaneous-request and masked-request cases expose these errors.

// File: rtl/exc_seq.sv
module exc_seq #(
  parameter int AW = 32,
  parameter int VALIGN = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_reset,
  input  logic          req_undef,
  input  logic          req_svc,
  input  logic          req_pabt,
  input  logic          req_dabt,
  input  logic          irq,
  input  logic          fiq,
  input  logic          ret_req,
  input  logic [AW-1:0] cur_pc,
  input  logic          vbase_we,
  input  logic [AW-1:0] vbase_in,
  input  logic          flags_we,
  input  logic [3:0]    flags_in,
  output logic          pc_load,
  output logic [AW-1:0] pc_target,
  output logic [4:0]    mode,
  output logic          irq_dis,
  output logic          fiq_dis,
  output logic [3:0]    flags
);
  localparam logic [4:0] M_USR = 5'b10000, M_FIQ = 5'b10001, M_IRQ = 5'b10010,
                         M_SVC = 5'b10011, M_ABT = 5'b10111, M_UND = 5'b11011;
  localparam int NBANK = 5;
  localparam int SW = 11;

  logic [AW-1:0] vbase;
  logic [AW-1:0] lr_bank [NBANK];
  logic [SW-1:0] sps_bank [NBANK];

  logic fiq_ok, irq_ok, take, set_f, save;
  logic [4:0] tgt_mode;
  logic [4:0] off;
  logic [2:0] tb, cb;
  logic ret_ok;
  logic [SW-1:0] cur_word, rest_word;

  function automatic logic [2:0] bank_of(input logic [4:0] m);
    case (m)
      M_FIQ:   return 3'd0;
      M_IRQ:   return 3'd1;
      M_SVC:   return 3'd2;
      M_ABT:   return 3'd3;
      default: return 3'd4;
    endcase
  endfunction

  assign fiq_ok = fiq & ~fiq_dis;
  assign irq_ok = irq & ~irq_dis;

  always_comb begin
    take = 1'b1; set_f = 1'b0; save = 1'b1;
    tgt_mode = M_SVC; off = 5'h00;
    if (req_reset) begin
      set_f = 1'b1; save = 1'b0;
    end else if (req_dabt) begin
      tgt_mode = M_ABT; off = 5'h10;
    end else if (fiq_ok) begin
      tgt_mode = M_FIQ; off = 5'h1C; set_f = 1'b1;
    end else if (irq_ok) begin
      tgt_mode = M_IRQ; off = 5'h18;
    end else if (req_pabt) begin
      tgt_mode = M_ABT; off = 5'h0C;
    end else if (req_undef) begin
      tgt_mode = M_UND; off = 5'h04;
    end else if (req_svc) begin
      off = 5'h08;
    end else begin
      take = 1'b0; save = 1'b0;
    end
  end

  assign tb        = bank_of(tgt_mode);
  assign cb        = bank_of(mode);
  assign ret_ok    = ret_req & (mode != M_USR) & ~take;
  assign cur_word  = {flags, irq_dis, fiq_dis, mode};
  assign rest_word = sps_bank[cb];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NBANK; k++) begin
        lr_bank[k]  <= '0;
        sps_bank[k] <= {4'b0, 1'b0, 1'b0, M_USR};
      end
    end else if (save) begin
      lr_bank[tb]  <= cur_pc + AW'(4);
      sps_bank[tb] <= cur_word;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vbase     <= '0;
      mode      <= M_SVC;
      irq_dis   <= 1'b1;
      fiq_dis   <= 1'b1;
      flags     <= '0;
      pc_load   <= 1'b0;
      pc_target <= '0;
    end else begin
      if (vbase_we) vbase <= {vbase_in[AW-1:VALIGN], VALIGN'(0)};
      pc_load <= take | ret_ok;
      if (take) begin
        mode      <= tgt_mode;
        irq_dis   <= 1'b1;
        if (set_f) fiq_dis <= 1'b1;
        pc_target <= vbase + AW'(off);
      end else if (ret_ok) begin
        {flags, irq_dis, fiq_dis, mode} <= rest_word;
        pc_target <= lr_bank[cb];
      end else if (flags_we) begin
        flags <= flags_in;
      end
    end
  end

  assert_priv_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (mode != M_USR && irq_dis));
  assert_irq_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_dis && !fiq_ok && !req_reset && !req_dabt && !req_pabt && !req_undef && !req_svc && !ret_req)
      |=> !pc_load);
  assert_user_ret_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && mode == M_USR && !take) |=> (mode == M_USR && !pc_load));
  assert_fiq_sets_f_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq && !fiq_dis && !req_reset && !req_dabt) |=> (fiq_dis && mode == M_FIQ));
  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !ret_ok) |=> !pc_load);
endmodule

// File: tb/test_exc_seq.sv
module test_exc_seq;
  logic clk = 0, rst_n = 0;
  logic req_reset = 0, req_undef = 0, req_svc = 0, req_pabt = 0, req_dabt = 0;
  logic irq = 0, fiq = 0, ret_req = 0, vbase_we = 0, flags_we = 0;
  logic [31:0] cur_pc = 0, vbase_in = 0;
  logic [3:0] flags_in = 0;
  logic pc_load, irq_dis, fiq_dis;
  logic [31:0] pc_target;
  logic [4:0] mode;
  logic [3:0] flags;
  int errors = 0, checks = 0;
  localparam logic [31:0] VB = 32'h1000_1000;

  exc_seq i_exc_seq (.*);

  always #4 clk = ~clk;

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
    req_reset = 0; req_undef = 0; req_svc = 0; req_pabt = 0; req_dabt = 0;
    ret_req = 0; vbase_we = 0; flags_we = 0;
  endtask

  task automatic expect_state(input string tag, input logic ld, input logic [31:0] pc,
                              input logic [4:0] m, input logic i, input logic f);
    chk({tag, " pc_load"}, 32'(pc_load), 32'(ld));
    if (ld) chk({tag, " pc_target"}, pc_target, pc);
    chk({tag, " mode"}, 32'(mode), 32'(m));
    chk({tag, " irq_dis"}, 32'(irq_dis), 32'(i));
    chk({tag, " fiq_dis"}, 32'(fiq_dis), 32'(f));
  endtask

  task automatic do_ret();
    ret_req = 1; step();
  endtask

  task automatic t_reset();
    expect_state("R1 reset", 0, 0, 5'b10011, 1, 1);
    chk("R1 flags", 32'(flags), 0);
  endtask

  task automatic t_boot();
    vbase_we = 1; vbase_in = 32'h1000_101F; step();
    chk("R10 no load on base write", 32'(pc_load), 0);
    do_ret();
    expect_state("R1 boot return", 1, 0, 5'b10000, 0, 0);
    step();
    chk("R10 one-cycle pulse", 32'(pc_load), 0);
    flags_we = 1; flags_in = 4'b1010; step();
    chk("R10 flags write", 32'(flags), 32'hA);
  endtask

  task automatic t_svc();
    cur_pc = 32'h100; req_svc = 1; step();
    expect_state("R4 svc entry", 1, VB + 8, 5'b10011, 1, 0);
    flags_we = 1; flags_in = 4'b0101; step();
    chk("R10 flags in handler", 32'(flags), 32'h5);
    irq = 1; cur_pc = 32'h200; step();
    expect_state("R7 masked irq", 0, 0, 5'b10011, 1, 0);
    irq = 0;
    do_ret();
    expect_state("R8 svc return", 1, 32'h104, 5'b10000, 0, 0);
    chk("R8 flags restored", 32'(flags), 32'hA);
    ret_req = 1; step();
    expect_state("R8 user return ignored", 0, 0, 5'b10000, 0, 0);
  endtask

  task automatic t_prio();
    req_reset = 1; req_dabt = 1; fiq = 1; irq = 1; req_pabt = 1; req_undef = 1; cur_pc = 32'h300;
    step();
    fiq = 0; irq = 0;
    expect_state("R3 reset wins", 1, VB, 5'b10011, 1, 1);
    do_ret();
    expect_state("R6 reset saved nothing", 1, 32'h104, 5'b10000, 0, 0);
    req_dabt = 1; fiq = 1; cur_pc = 32'h400; step();
    fiq = 0;
    expect_state("R3 dabt over fiq", 1, VB + 32'h10, 5'b10111, 1, 0);
    do_ret();
    expect_state("R8 abort return", 1, 32'h404, 5'b10000, 0, 0);
    req_pabt = 1; req_undef = 1; cur_pc = 32'h500; step();
    expect_state("R3 pabt over undef", 1, VB + 32'h0C, 5'b10111, 1, 0);
    do_ret();
    req_undef = 1; req_svc = 1; cur_pc = 32'h600; step();
    expect_state("R2 undef over svc", 1, VB + 32'h04, 5'b11011, 1, 0);
    do_ret();
    expect_state("R8 undef return", 1, 32'h604, 5'b10000, 0, 0);
  endtask

  task automatic t_nest();
    irq = 1; cur_pc = 32'h700; step();
    irq = 0;
    expect_state("R5 irq entry", 1, VB + 32'h18, 5'b10010, 1, 0);
    flags_we = 1; flags_in = 4'b0011; step();
    fiq = 1; cur_pc = 32'h800; step();
    fiq = 0;
    expect_state("R9 fiq preempts", 1, VB + 32'h1C, 5'b10001, 1, 1);
    fiq = 1; step();
    fiq = 0;
    expect_state("R7 masked fiq", 0, 0, 5'b10001, 1, 1);
    do_ret();
    expect_state("R9 back to irq handler", 1, 32'h804, 5'b10010, 1, 0);
    chk("R9 handler flags", 32'(flags), 32'h3);
    do_ret();
    expect_state("R6 irq bank intact", 1, 32'h704, 5'b10000, 0, 0);
    chk("R8 user flags", 32'(flags), 32'hA);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    #1;
    t_reset();
    t_boot();
    t_svc();
    t_prio();
    t_nest();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule